// File: doc/BRIEF.md
# Serial Configuration Register Port

This block keeps a 24-bit configuration word behind a chip-select-framed serial port and presents the word's fields as parallel outputs to the rest of the chip. The word carries an output-coding select, an 11-bit conversion-rate code, a 3-bit operating mode, a bipolar/unipolar select and a low byte of gain and miscellaneous control bits. Other register addresses are stubs. Reads from them return zero and writes to them are dropped.

An access opens when chip select goes low. It begins with an 8-bit instruction shifted in on the shared data pin. One to three data bytes follow. In this two-wire arrangement the same pin carries the instruction from the host and any read data back to it. The separate output pin stays three-stated. The serial clock may idle low or high, as chosen by a polarity input. Data is sampled on the edge that leaves the idle level and changed on the edge that returns to it.

All port inputs are resynchronised to the system clock, so the serial clock must be several times slower than the system clock.

Top module: `cfgsp_serial_port`

## Requirements
- R1: One cycle after synchronous reset the word reads 0x00A300: coding select 0, rate code 10, mode 3'b001 (self-calibration), bipolar 1, low byte 0x00.
- R2: Field positions in the word are: bit 23 coding select, bits 22..12 rate code, bits 11..9 mode, bit 8 bipolar select, bits 7..0 gain/misc byte. A three-byte write shows up on the matching field outputs.
- R3: The instruction byte is sent MSB first. Bit 7 is 1 for read and 0 for write. Bits 6..5 hold the byte count minus one, with code 3 treated as three bytes. Bits 4..0 hold the address, where 0, 1 and 2 select byte 0 (bits 7..0), byte 1 and byte 2 (bits 23..16). Data bytes move MSB first, starting at the addressed byte and then going down in byte index. A byte past byte 0 is a stub.
- R4: Read data is driven on the data pin. It changes after the return-to-idle clock edge and is valid at the next leaving-idle edge, and the first bit is ready for the leaving-idle edge that follows the eighth instruction bit.
- R5: The data pin is driven only during the data phase of a read. The separate output pin is never driven.
- R6: Accesses behave the same with the serial clock idling low and idling high.
- R7: Raising chip select at any point ends the access and releases the data pin, and the next access starts from a fresh instruction.
- R8: A written byte reaches the word only once all 8 of its bits have been sampled. A byte cut short by chip select leaves the word unchanged.
- R9: After every committed byte, a rate code below 10 is replaced by 10. Codes of 10 and above are kept.
- R10: Addresses 3 to 31 are stubs: reads return 0x00 and writes leave the word unchanged.
- R11: Clock edges after the requested number of bytes, while chip select stays low, have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; frames one access |
| sclk | input | 1 | Serial clock from the host |
| clk_idle_high | input | 1 | 1 when the serial clock idles high, 0 when it idles low |
| sdio | inout | 1 | Shared serial data pin (instruction, write data, read data) |
| sdo | output | 1 | Separate serial output, always three-stated in this arrangement |
| coding_twos | output | 1 | Output coding select (word bit 23) |
| rate_code | output | 11 | Conversion-rate code (word bits 22..12) |
| op_mode | output | 3 | Operating mode (word bits 11..9) |
| bipolar | output | 1 | Bipolar (1) / unipolar (0) select (word bit 8) |
| gain_misc | output | 8 | Gain and miscellaneous bits (word bits 7..0) |

## Verification
The assertions check on every cycle that the word holds its reset value right after reset and that the rate code never falls below 10. They also check that the word changes only on a commit, that a committed low byte lands unchanged, and that the data pin is released soon after deselection and driven only during a read's data phase. Other behaviour depends on bit order and is visible only in the bench's scenarios. These scenarios cover the instruction decode, the descending byte order across the stub boundary, and correct operation under both clock idle levels. They also show that a partial byte is dropped on abort, that bits after the byte count are ignored, and the exact read data seen at the pin.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int WORD_W = 24;
    localparam int BYTE_W = 8;
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int RATE_W = 11;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 2;
    localparam int IDX_W  = 2;

    localparam logic [RATE_W-1:0] RATE_MIN     = 11'd10;
    localparam logic [MODE_W-1:0] MODE_SELFCAL = 3'b001;

    // Field layout of the configuration word, MSB first
    typedef struct packed {
        logic              coding_twos;
        logic [RATE_W-1:0] rate;
        logic [MODE_W-1:0] mode;
        logic              bipolar;
        logic [BYTE_W-1:0] gain_misc;
    } cfg_word_t;

    localparam cfg_word_t CFG_RESET = '{
        coding_twos: 1'b0,
        rate:        RATE_MIN,
        mode:        MODE_SELFCAL,
        bipolar:     1'b1,
        gain_misc:   '0
    };

    // Instruction byte layout
    typedef struct packed {
        logic              is_read;
        logic [CNT_W-1:0]  cnt_code;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INSTR,
        ST_DATA,
        ST_DONE
    } ser_state_e;

    // Remaining bytes after the first; the top code saturates at NBYTES
    function automatic logic [CNT_W-1:0] extra_bytes(input logic [CNT_W-1:0] code);
        logic [CNT_W-1:0] lim;
        lim = CNT_W'(NBYTES - 1);
        return (code > lim) ? lim : code;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input cfg_word_t w,
                                                    input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] flat;
        flat = w;
        return flat[int'(idx)*BYTE_W +: BYTE_W];
    endfunction

    // Insert one byte, then keep the rate code at or above its floor
    function automatic cfg_word_t merge_byte(input cfg_word_t cur,
                                             input logic [IDX_W-1:0] idx,
                                             input logic [BYTE_W-1:0] val);
        logic [WORD_W-1:0] flat;
        cfg_word_t         res;
        flat = cur;
        flat[int'(idx)*BYTE_W +: BYTE_W] = val;
        res = cfg_word_t'(flat);
        if (res.rate < RATE_MIN) res.rate = RATE_MIN;
        return res;
    endfunction

endpackage

// File: rtl/cfgsp_sync.sv
module cfgsp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_in,
    input  logic idle_high,
    output logic sel,
    output logic lead,
    output logic trail,
    output logic sdi
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] clk_sh;
    logic [TOP:0] sel_sh;
    logic [TOP:0] dat_sh;
    logic         clk_prev;

    // Normalised clock: 0 at idle regardless of polarity
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh   <= '0;
            sel_sh   <= '0;
            dat_sh   <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sh   <= {clk_sh[TOP-1:0], sclk ^ idle_high};
            sel_sh   <= {sel_sh[TOP-1:0], ~cs_n};
            dat_sh   <= {dat_sh[TOP-1:0], sdio_in};
            clk_prev <= clk_sh[TOP];
        end
    end

    assign sel   = sel_sh[TOP];
    assign sdi   = dat_sh[TOP];
    assign lead  = clk_sh[TOP] & ~clk_prev;
    assign trail = ~clk_sh[TOP] & clk_prev;

endmodule

// File: rtl/cfgsp_engine.sv
module cfgsp_engine
    import cfgsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              lead,
    input  logic              trail,
    input  logic              sdi,
    input  cfg_word_t         rd_word,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              drv_en,
    output logic              drv_bit
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    ser_state_e        state;
    logic [BIT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              is_read;
    logic [CNT_W-1:0]  left;
    logic [IDX_W-1:0]  ptr;
    logic              in_range;

    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] rx_byte;
    instr_t            ins;

    always_comb begin
        rx_byte = {shreg[BYTE_W-2:0], sdi};
        ins     = instr_t'(rx_byte);
        rd_byte = in_range ? pick_byte(rd_word, ptr) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            is_read  <= 1'b0;
            left     <= '0;
            ptr      <= '0;
            in_range <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            drv_en   <= 1'b0;
            drv_bit  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (!sel) begin
                state  <= ST_IDLE;
                drv_en <= 1'b0;
                bitcnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        state  <= ST_INSTR;
                        bitcnt <= '0;
                    end
                    ST_INSTR: begin
                        if (lead) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                is_read  <= ins.is_read;
                                left     <= extra_bytes(ins.cnt_code);
                                ptr      <= ins.addr[IDX_W-1:0];
                                in_range <= (ins.addr[ADDR_W-1:IDX_W] == '0) &&
                                            (int'(ins.addr[IDX_W-1:0]) < NBYTES);
                                state    <= ST_DATA;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (trail && is_read) begin
                            if (bitcnt == '0) begin
                                drv_en  <= 1'b1;
                                drv_bit <= rd_byte[BYTE_W-1];
                                shreg   <= {rd_byte[BYTE_W-2:0], 1'b0};
                            end else begin
                                drv_bit <= shreg[BYTE_W-1];
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                        if (lead) begin
                            if (!is_read) shreg <= rx_byte;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                if (!is_read && in_range) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= rx_byte;
                                end
                                if (ptr == '0) in_range <= 1'b0;
                                else           ptr      <= ptr - 1'b1;
                                if (left == '0) begin
                                    state  <= ST_DONE;
                                    drv_en <= 1'b0;
                                end else begin
                                    left <= left - 1'b1;
                                end
                            end
                        end
                    end
                    ST_DONE: begin
                        drv_en <= 1'b0;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7: deselection releases the data pin on the following cycle
    assert_release_on_deselect_R7: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !drv_en);

    // R5: the pin is driven only inside a read's data phase
    assert_drive_only_in_read_R5: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (is_read && state == ST_DATA));

    // R10: no commit is ever aimed past the last real byte
    assert_commit_in_word_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NBYTES));

endmodule

// File: rtl/cfgsp_regs.sv
module cfgsp_regs
    import cfgsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_word_t         word
);

    always_ff @(posedge clk) begin
        if (rst)        word <= CFG_RESET;
        else if (wr_en) word <= merge_byte(word, wr_idx, wr_data);
    end

    // R1: defined per-field reset values
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (word == CFG_RESET));

    // R9: rate code floor
    assert_rate_floor_R9: assert property (@(posedge clk) disable iff (rst)
        word.rate >= RATE_MIN);

    // R8: the word changes only on a completed byte
    assert_hold_without_commit_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word));

    // R2: a committed low byte lands unchanged in bits 7..0
    assert_low_byte_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == '0) |=> (word.gain_misc == $past(wr_data)));

endmodule

// File: rtl/cfgsp_serial_port.sv
module cfgsp_serial_port
    import cfgsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              clk_idle_high,
    inout  wire               sdio,
    output logic              sdo,
    output logic              coding_twos,
    output logic [RATE_W-1:0] rate_code,
    output logic [MODE_W-1:0] op_mode,
    output logic              bipolar,
    output logic [BYTE_W-1:0] gain_misc
);

    logic              sel, lead, trail, sdi;
    logic              wr_en, drv_en, drv_bit;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    cfg_word_t         word;

    cfgsp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdio_in   (sdio),
        .idle_high (clk_idle_high),
        .sel       (sel),
        .lead      (lead),
        .trail     (trail),
        .sdi       (sdi)
    );

    cfgsp_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .lead    (lead),
        .trail   (trail),
        .sdi     (sdi),
        .rd_word (word),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .drv_en  (drv_en),
        .drv_bit (drv_bit)
    );

    cfgsp_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .word    (word)
    );

    assign sdio = drv_en ? drv_bit : 1'bz;
    assign sdo  = 1'bz;

    assign coding_twos = word.coding_twos;
    assign rate_code   = word.rate;
    assign op_mode     = word.mode;
    assign bipolar     = word.bipolar;
    assign gain_misc   = word.gain_misc;

endmodule

// File: tb/sim_cfgsp_serial_port.sv
`timescale 1ns/1ps
module sim_cfgsp_serial_port;

    localparam time HALF = 80ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic idle_high = 1'b0;
    logic tb_oe = 1'b0;
    logic tb_bit = 1'b0;
    wire  sdio;
    wire  sdo;
    logic        coding_twos, bipolar;
    logic [10:0] rate_code;
    logic [2:0]  op_mode;
    logic [7:0]  gain_misc;

    pullup (sdio);
    pullup (sdo);
    assign sdio = tb_oe ? tb_bit : 1'bz;

    always #5ns clk = ~clk;

    cfgsp_serial_port u0 (
        .clk           (clk),
        .rst           (rst),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .clk_idle_high (idle_high),
        .sdio          (sdio),
        .sdo           (sdo),
        .coding_twos   (coding_twos),
        .rate_code     (rate_code),
        .op_mode       (op_mode),
        .bipolar       (bipolar),
        .gain_misc     (gain_misc)
    );

    typedef struct {
        logic [7:0] val;
        string      req;
    } sb_item_t;

    sb_item_t   exp_q[$];
    logic [7:0] got_q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compare read bytes as they are captured
    always @(negedge clk) begin
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            sb_item_t e;
            logic [7:0] g;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            check(e.req, {24'd0, g}, {24'd0, e.val});
        end
    end

    task automatic begin_xfer(input logic idle);
        idle_high = idle;
        sclk = idle;
        #(HALF);
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic end_xfer();
        tb_oe = 1'b0;
        #(HALF);
        cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic xfer_bit(input logic b, input logic drive, output logic got);
        tb_oe  = drive;
        tb_bit = b;
        #(HALF);
        got  = sdio;
        sclk = ~idle_high;
        #(HALF);
        sclk = idle_high;
    endtask

    task automatic xfer_byte(input logic [7:0] b, input logic drive, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            logic g;
            xfer_bit(b[i], drive, g);
            got[i] = g;
        end
    endtask

    // R3 instruction byte: {read, count-1 [1:0], address [4:0]}
    function automatic logic [7:0] mk_instr(input logic rd, input logic [1:0] cnt, input logic [4:0] a);
        return {rd, cnt, a};
    endfunction

    task automatic wr_access(input logic idle, input logic [4:0] a, input logic [1:0] cnt,
                             input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] g;
        begin_xfer(idle);
        xfer_byte(mk_instr(1'b0, cnt, a), 1'b1, g);
        xfer_byte(b0, 1'b1, g);
        if (cnt >= 2'd1) xfer_byte(b1, 1'b1, g);
        if (cnt >= 2'd2) xfer_byte(b2, 1'b1, g);
        end_xfer();
    endtask

    task automatic rd_access(input logic idle, input logic [4:0] a, input logic [1:0] cnt,
                             input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                             input string req);
        logic [7:0] g;
        int n;
        n = (cnt >= 2'd2) ? 3 : int'(cnt) + 1;
        begin_xfer(idle);
        xfer_byte(mk_instr(1'b1, cnt, a), 1'b1, g);
        for (int i = 0; i < n; i++) begin
            sb_item_t it;
            it.val = (i == 0) ? e0 : (i == 1) ? e1 : e2;
            it.req = req;
            exp_q.push_back(it);
            xfer_byte(8'h00, 1'b0, g);
            got_q.push_back(g);
        end
        end_xfer();
    endtask

    task automatic check_fields(input string req, input logic c, input logic [10:0] r,
                                input logic [2:0] m, input logic b, input logic [7:0] gm);
        check({req, " coding"}, {31'd0, coding_twos}, {31'd0, c});
        check({req, " rate"},   {21'd0, rate_code},   {21'd0, r});
        check({req, " mode"},   {29'd0, op_mode},     {29'd0, m});
        check({req, " bipolar"},{31'd0, bipolar},     {31'd0, b});
        check({req, " gain"},   {24'd0, gain_misc},   {24'd0, gm});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #1ms;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] g;
        logic b;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1ns;

        // R1 reset values, seen on the field outputs and by read-back
        check_fields("R1", 1'b0, 11'd10, 3'b001, 1'b1, 8'h00);
        rd_access(1'b0, 5'd2, 2'd2, 8'h00, 8'hA3, 8'h00, "R1 R4 read-back");
        check("R5 sdio released after read", {31'd0, sdio}, 32'd1);
        check("R5 sdo undriven", {31'd0, sdo}, 32'd1);

        // R2 / R6 full write with clock idling high
        wr_access(1'b1, 5'd2, 2'd2, 8'h85, 8'h46, 8'h5A);
        check_fields("R2 R6", 1'b1, 11'd84, 3'd3, 1'b0, 8'h5A);
        rd_access(1'b1, 5'd1, 2'd1, 8'h46, 8'h5A, 8'h00, "R3 R6 read from byte 1");

        // R3 descending past byte 0 reaches the stub
        rd_access(1'b0, 5'd0, 2'd2, 8'h5A, 8'h00, 8'h00, "R3 descend past byte 0");

        // R10 stub addresses
        wr_access(1'b0, 5'd5, 2'd0, 8'hFF, 8'h00, 8'h00);
        rd_access(1'b0, 5'd5, 2'd0, 8'h00, 8'h00, 8'h00, "R10 stub read");
        rd_access(1'b0, 5'd2, 2'd3, 8'h85, 8'h46, 8'h5A, "R10 word unchanged, R3 code 3");

        // R9 rate clamp
        wr_access(1'b1, 5'd2, 2'd1, 8'h00, 8'h06, 8'h00);
        check("R9 clamped rate", {21'd0, rate_code}, 32'd10);
        rd_access(1'b1, 5'd1, 2'd0, 8'hA6, 8'h00, 8'h00, "R9 clamped byte 1");
        wr_access(1'b0, 5'd1, 2'd0, 8'hB6, 8'h00, 8'h00);
        check_fields("R9 rate 11 kept", 1'b0, 11'd11, 3'd3, 1'b0, 8'h5A);

        // R8 / R7 write aborted in the middle of the second byte
        wr_access(1'b0, 5'd2, 2'd0, 8'h7F, 8'h00, 8'h00);
        begin_xfer(1'b0);
        xfer_byte(mk_instr(1'b0, 2'd1, 5'd1), 1'b1, g);
        xfer_byte(8'h3C, 1'b1, g);
        for (int i = 0; i < 4; i++) xfer_bit(1'b1, 1'b1, b);
        end_xfer();
        check_fields("R8 partial byte dropped", 1'b0, 11'h7F3, 3'd6, 1'b0, 8'h5A);
        rd_access(1'b0, 5'd2, 2'd2, 8'h7F, 8'h3C, 8'h5A, "R8 read-back");

        // R7 read aborted while the first bit (0) is on the pin
        begin_xfer(1'b1);
        xfer_byte(mk_instr(1'b1, 2'd0, 5'd2), 1'b1, g);
        tb_oe = 1'b0;
        #(HALF);
        check("R4 first read bit driven", {31'd0, sdio}, 32'd0);
        cs_n = 1'b1;
        #(4 * HALF);
        check("R7 pin released on abort", {31'd0, sdio}, 32'd1);
        rd_access(1'b0, 5'd0, 2'd0, 8'h5A, 8'h00, 8'h00, "R7 fresh access after abort");

        // R11 extra bits after the byte count
        begin_xfer(1'b0);
        xfer_byte(mk_instr(1'b0, 2'd0, 5'd0), 1'b1, g);
        xfer_byte(8'h11, 1'b1, g);
        xfer_byte(8'hEE, 1'b1, g);
        end_xfer();
        check("R11 extra bits ignored", {24'd0, gain_misc}, 32'h11);
        rd_access(1'b1, 5'd0, 2'd0, 8'h11, 8'h00, 8'h00, "R11 read-back");
        check("R5 sdo undriven at end", {31'd0, sdo}, 32'd1);

        wait (exp_q.size() == 0 && got_q.size() == 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule